// File: doc/BRIEF.md
# Memory Hole Decoder with Reclaim

The block sorts every physical address into one of two targets: system DRAM or the PCI bus. Up to three programmable holes (a low, a middle and a high hole) can be opened in the DRAM address space. An access that falls inside an enabled hole goes to PCI, and DRAM claims no access at or above the top of memory. When reclaim is switched on, the DRAM hidden behind the holes is not lost. It reappears in a window that starts at the nominal top of memory and is as large as the sum of the enabled hole sizes.

The decoder works in 1 MB pages. Each hole has a page base, a power-of-two size of 1 to 32 MB and an enable. Hole membership is a masked compare of the address page with the base, so base bits below the hole size are ignored. The block also checks the hole programming. A bad size code, a low hole that is not the lowest, or two enabled holes that overlap raises an error flag. While that flag is up, every access is sent to PCI. Results are registered, so each address is decoded one cycle after it is presented.

Top module: `mem_hole_decoder`

## Requirements
- R1: A hole size is a 3-bit log2 code in MB: code 0 is 1 MB, 1 is 2 MB, and so on up to 5 for 32 MB. Addresses are decoded by 1 MB page, which is addr_i[31:20]. Hole i uses bits [12*i +: 12] of hole_base_i, bits [3*i +: 3] of hole_size_i and bit i of hole_en_i, where i is 0 for the low hole, 1 for the middle hole and 2 for the high hole.
- R2: An address whose page matches an enabled hole base in all bits above the size boundary goes to PCI (to_pci_o=1, dram_addr_o=0). Base bits below the size boundary are ignored.
- R3: An address below top_mem_i (in MB pages) that hits no enabled hole goes to DRAM with dram_addr_o equal to the address.
- R4: An address at or above top_mem_i goes to PCI unless it lies inside the reclaim window. With reclaim_en_i=0, every such address goes to PCI.
- R5: With reclaim_en_i=1, page top_mem_i+k, for k below the total enabled hole size, goes to DRAM at hidden page k. The hidden pages are counted through the holes in ascending base order (the low hole first), and the low 20 address bits are preserved.
- R6: A disabled hole matches no address and adds nothing to the reclaim window.
- R7: An enabled hole with size code 6 or 7 sets cfg_err_o. The same code on a disabled hole does not.
- R8: cfg_err_o is set when the enabled low hole base is not below the base of another enabled hole.
- R9: cfg_err_o is set when any two enabled holes overlap.
- R10: While cfg_err_o is 1, to_pci_o is 1 and dram_addr_o is 0.
- R11: Outputs are registered and reflect the inputs of the previous clock edge. During reset, to_pci_o=1, dram_addr_o=0 and cfg_err_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Physical address |
| hole_en_i | input | 3 | Enable for each hole |
| hole_base_i | input | 36 | Base page for each hole, 12 bits per hole |
| hole_size_i | input | 9 | log2 size code for each hole, 3 bits per hole |
| top_mem_i | input | 12 | Nominal top of memory, in 1 MB pages |
| reclaim_en_i | input | 1 | Enables remapping of hidden DRAM above the top of memory |
| to_pci_o | output | 1 | 1: the access goes to PCI; 0: the access goes to DRAM |
| dram_addr_o | output | 32 | Translated DRAM address, 0 when the access goes to PCI |
| cfg_err_o | output | 1 | Hole programming is illegal |

## Verification
A wrong hole mask or base shows up on the ports one cycle after the address is presented. Either an address at a hole edge lands on the wrong side of to_pci_o, or a reclaimed page gets the wrong dram_addr_o. Wrong sort or window state is visible only when reclaim is on and the address lies in the window above the top of memory. The tests therefore step through each hole boundary and through each page of the window, with the holes both in order and swapped. A missed configuration error appears as a DRAM grant on the next access under the bad programming, so each error case is followed by an ordinary low address.

// File: rtl/mhd_pkg.sv
package mhd_pkg;
  localparam int unsigned NUM_HOLES = 3;
  localparam int unsigned SZ_W      = 3;
  localparam int unsigned MAX_LOG2  = 5;

  typedef enum int unsigned {
    HOLE_LOW  = 0,
    HOLE_MID  = 1,
    HOLE_HIGH = 2
  } hole_idx_e;
endpackage

// File: rtl/mhd_hole_slot.sv
module mhd_hole_slot
  import mhd_pkg::*;
#(
  parameter int unsigned PN_W = 12
) (
  input  logic            en_i,
  input  logic [PN_W-1:0] base_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic [PN_W-1:0] page_i,
  output logic            hit_o,
  output logic            bad_size_o,
  output logic [PN_W-1:0] eff_base_o,
  output logic [PN_W-1:0] mask_o,
  output logic [PN_W-1:0] span_o
);
  localparam logic [PN_W-1:0] ONE = PN_W'(1);
  logic [SZ_W-1:0] log_c;

  always_comb begin
    bad_size_o = en_i && (size_i > SZ_W'(MAX_LOG2));
    log_c      = (size_i > SZ_W'(MAX_LOG2)) ? SZ_W'(MAX_LOG2) : size_i;
    mask_o     = {PN_W{1'b1}} << log_c;
    eff_base_o = base_i & mask_o;
    hit_o      = en_i && ((page_i & mask_o) == eff_base_o);
    span_o     = en_i ? (ONE << log_c) : '0;
  end
endmodule

// File: rtl/mhd_cfg_check.sv
module mhd_cfg_check
  import mhd_pkg::*;
#(
  parameter int unsigned PN_W = 12
) (
  input  logic [NUM_HOLES-1:0]           en_i,
  input  logic [NUM_HOLES-1:0]           bad_size_i,
  input  logic [NUM_HOLES-1:0][PN_W-1:0] eff_base_i,
  input  logic [NUM_HOLES-1:0][PN_W-1:0] mask_i,
  output logic                           err_o
);
  logic overlap, order_bad;

  always_comb begin
    overlap   = 1'b0;
    order_bad = 1'b0;
    for (int i = 0; i < NUM_HOLES; i++) begin
      for (int j = i + 1; j < NUM_HOLES; j++) begin
        // aligned power-of-two blocks overlap iff equal under the coarser mask
        if (en_i[i] && en_i[j] &&
            ((eff_base_i[i] & mask_i[i] & mask_i[j]) ==
             (eff_base_i[j] & mask_i[i] & mask_i[j])))
          overlap = 1'b1;
      end
      if (i != HOLE_LOW && en_i[HOLE_LOW] && en_i[i] &&
          !(eff_base_i[HOLE_LOW] < eff_base_i[i]))
        order_bad = 1'b1;
    end
    err_o = overlap || order_bad || (|bad_size_i);
  end
endmodule

// File: rtl/mhd_reclaim.sv
module mhd_reclaim
  import mhd_pkg::*;
#(
  parameter int unsigned PN_W = 12
) (
  input  logic                           reclaim_en_i,
  input  logic [PN_W-1:0]                page_i,
  input  logic [PN_W-1:0]                top_i,
  input  logic [NUM_HOLES-1:0][PN_W-1:0] eff_base_i,
  input  logic [NUM_HOLES-1:0][PN_W-1:0] span_i,
  output logic                           in_win_o,
  output logic [PN_W-1:0]                dram_page_o
);
  localparam int unsigned EW = PN_W + 2;

  logic [EW-1:0] base_a, base_b, base_c, span_a, span_b, span_c;
  logic [EW-1:0] page_x, top_x, end_x, off, cut1, cut2, pg_x;

  always_comb begin
    // low hole first, then middle/high by ascending base
    base_a = EW'(eff_base_i[HOLE_LOW]);
    span_a = EW'(span_i[HOLE_LOW]);
    if (eff_base_i[HOLE_HIGH] < eff_base_i[HOLE_MID]) begin
      base_b = EW'(eff_base_i[HOLE_HIGH]); span_b = EW'(span_i[HOLE_HIGH]);
      base_c = EW'(eff_base_i[HOLE_MID]);  span_c = EW'(span_i[HOLE_MID]);
    end else begin
      base_b = EW'(eff_base_i[HOLE_MID]);  span_b = EW'(span_i[HOLE_MID]);
      base_c = EW'(eff_base_i[HOLE_HIGH]); span_c = EW'(span_i[HOLE_HIGH]);
    end
    page_x = EW'(page_i);
    top_x  = EW'(top_i);
    end_x  = top_x + span_a + span_b + span_c;
    off    = page_x - top_x;
    cut1   = span_a;
    cut2   = span_a + span_b;
    in_win_o = reclaim_en_i && (page_x >= top_x) && (page_x < end_x);
    if (off < cut1)      pg_x = base_a + off;
    else if (off < cut2) pg_x = base_b + off - cut1;
    else                 pg_x = base_c + off - cut2;
    dram_page_o = pg_x[PN_W-1:0];
  end
endmodule

// File: rtl/mem_hole_decoder.sv
module mem_hole_decoder
  import mhd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned MB_SHIFT = 20
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [NUM_HOLES-1:0]      hole_en_i,
  input  logic [NUM_HOLES*(ADDR_W-MB_SHIFT)-1:0] hole_base_i,
  input  logic [NUM_HOLES*SZ_W-1:0] hole_size_i,
  input  logic [ADDR_W-MB_SHIFT-1:0] top_mem_i,
  input  logic                      reclaim_en_i,
  output logic                      to_pci_o,
  output logic [ADDR_W-1:0]         dram_addr_o,
  output logic                      cfg_err_o
);
  localparam int unsigned PN_W = ADDR_W - MB_SHIFT;

  logic [PN_W-1:0]                page;
  logic [NUM_HOLES-1:0]           hit, bad_size;
  logic [NUM_HOLES-1:0][PN_W-1:0] eff_base, mask, span;
  logic                           cfg_err, in_win, below_top, pci_d;
  logic [PN_W-1:0]                win_page;
  logic [ADDR_W-1:0]              dram_d;

  assign page = addr_i[ADDR_W-1 -: PN_W];

  for (genvar g = 0; g < NUM_HOLES; g++) begin : g_hole
    mhd_hole_slot #(.PN_W(PN_W)) u_slot (
      .en_i      (hole_en_i[g]),
      .base_i    (hole_base_i[g*PN_W +: PN_W]),
      .size_i    (hole_size_i[g*SZ_W +: SZ_W]),
      .page_i    (page),
      .hit_o     (hit[g]),
      .bad_size_o(bad_size[g]),
      .eff_base_o(eff_base[g]),
      .mask_o    (mask[g]),
      .span_o    (span[g])
    );
  end

  mhd_cfg_check #(.PN_W(PN_W)) u_cfg (
    .en_i      (hole_en_i),
    .bad_size_i(bad_size),
    .eff_base_i(eff_base),
    .mask_i    (mask),
    .err_o     (cfg_err)
  );

  mhd_reclaim #(.PN_W(PN_W)) u_reclaim (
    .reclaim_en_i(reclaim_en_i),
    .page_i      (page),
    .top_i       (top_mem_i),
    .eff_base_i  (eff_base),
    .span_i      (span),
    .in_win_o    (in_win),
    .dram_page_o (win_page)
  );

  always_comb begin
    below_top = page < top_mem_i;
    pci_d     = cfg_err || (|hit) || !(below_top || in_win);
    if (pci_d)          dram_d = '0;
    else if (below_top) dram_d = addr_i;
    else                dram_d = {win_page, addr_i[MB_SHIFT-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_pci_o    <= 1'b1;
      dram_addr_o <= '0;
      cfg_err_o   <= 1'b0;
    end else begin
      to_pci_o    <= pci_d;
      dram_addr_o <= dram_d;
      cfg_err_o   <= cfg_err;
    end
  end
endmodule

// File: rtl/mem_hole_decoder_chk.sv
module mem_hole_decoder_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned MB_SHIFT = 20
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [ADDR_W-MB_SHIFT-1:0] top_mem_i,
  input logic                       reclaim_en_i,
  input logic                       to_pci_o,
  input logic [ADDR_W-1:0]          dram_addr_o,
  input logic                       cfg_err_o
);
  localparam int unsigned PN_W = ADDR_W - MB_SHIFT;

  a_r10_err_forces_pci: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> to_pci_o);

  a_r2_pci_zero_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_pci_o |-> (dram_addr_o == '0));

  a_r3_below_top_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!to_pci_o && $past(addr_i[ADDR_W-1 -: PN_W] < top_mem_i))
      |-> (dram_addr_o == $past(addr_i)));

  a_r4_no_reclaim_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!to_pci_o && !$past(reclaim_en_i)) |-> (dram_addr_o == $past(addr_i)));

  a_r5_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !to_pci_o |-> (dram_addr_o[MB_SHIFT-1:0] == $past(addr_i[MB_SHIFT-1:0])));
endmodule

bind mem_hole_decoder mem_hole_decoder_chk #(.ADDR_W(ADDR_W), .MB_SHIFT(MB_SHIFT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .top_mem_i   (top_mem_i),
  .reclaim_en_i(reclaim_en_i),
  .to_pci_o    (to_pci_o),
  .dram_addr_o (dram_addr_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/mem_hole_decoder_tb_top.sv
module mem_hole_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic [2:0]  hole_en_i = '0;
  logic [35:0] hole_base_i = '0;
  logic [8:0]  hole_size_i = '0;
  logic [11:0] top_mem_i = '0;
  logic        reclaim_en_i = 1'b0;
  logic        to_pci_o;
  logic [31:0] dram_addr_o;
  logic        cfg_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  mem_hole_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .hole_en_i(hole_en_i),
    .hole_base_i(hole_base_i), .hole_size_i(hole_size_i), .top_mem_i(top_mem_i),
    .reclaim_en_i(reclaim_en_i), .to_pci_o(to_pci_o), .dram_addr_o(dram_addr_o),
    .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_hole(input int idx, input logic en, input logic [11:0] base,
                          input logic [2:0] sz);
    hole_en_i[idx]           = en;
    hole_base_i[idx*12 +: 12] = base;
    hole_size_i[idx*3 +: 3]   = sz;
  endtask

  // low [16,18), mid [32,36), high [48,49), top 64, reclaim on: window [64,71)
  task automatic cfg_base();
    @(negedge clk_i);
    set_hole(0, 1'b1, 12'd16, 3'd1);
    set_hole(1, 1'b1, 12'd32, 3'd2);
    set_hole(2, 1'b1, 12'd48, 3'd0);
    top_mem_i    = 12'd64;
    reclaim_en_i = 1'b1;
  endtask

  task automatic look(input string tag, input logic [31:0] a, input logic pci,
                      input logic [31:0] exp_addr, input logic err);
    @(negedge clk_i);
    addr_i = a;
    @(negedge clk_i);
    chk({tag, " pci"}, 32'(to_pci_o), 32'(pci));
    chk({tag, " addr"}, dram_addr_o, exp_addr);
    chk({tag, " err"}, 32'(cfg_err_o), 32'(err));
  endtask

  task automatic t_reset();
    chk("R11 reset pci", 32'(to_pci_o), 32'd1);
    chk("R11 reset addr", dram_addr_o, 32'd0);
    chk("R11 reset err", 32'(cfg_err_o), 32'd0);
  endtask

  task automatic t_holes();
    cfg_base();
    look("R3 low dram", 32'h0012_3456, 1'b0, 32'h0012_3456, 1'b0);
    look("R2 low hole", 32'h0110_ABCD, 1'b1, 32'h0, 1'b0);
    look("R1 low hole end", 32'h0120_0000, 1'b0, 32'h0120_0000, 1'b0);
    look("R1 mid last page", 32'h023F_FFFF, 1'b1, 32'h0, 1'b0);
    look("R1 mid end", 32'h0240_0001, 1'b0, 32'h0240_0001, 1'b0);
    look("R2 high hole", 32'h0300_0010, 1'b1, 32'h0, 1'b0);
    look("R1 high end", 32'h0310_0000, 1'b0, 32'h0310_0000, 1'b0);
  endtask

  task automatic t_reclaim();
    cfg_base();
    look("R5 win 0", 32'h0400_1234, 1'b0, 32'h0100_1234, 1'b0);
    look("R5 win 1", 32'h0410_0000, 1'b0, 32'h0110_0000, 1'b0);
    look("R5 win 2", 32'h0420_0042, 1'b0, 32'h0200_0042, 1'b0);
    look("R5 win 5", 32'h045F_FFFF, 1'b0, 32'h023F_FFFF, 1'b0);
    look("R5 win 6", 32'h0460_0007, 1'b0, 32'h0300_0007, 1'b0);
    look("R4 win end", 32'h0470_0000, 1'b1, 32'h0, 1'b0);
    look("R4 far above", 32'h0800_0000, 1'b1, 32'h0, 1'b0);
    @(negedge clk_i); reclaim_en_i = 1'b0;
    look("R4 reclaim off", 32'h0400_1234, 1'b1, 32'h0, 1'b0);
    look("R3 reclaim off low", 32'h003F_0000, 1'b0, 32'h003F_0000, 1'b0);
  endtask

  task automatic t_swap_and_mask();
    cfg_base();
    @(negedge clk_i);
    set_hole(1, 1'b1, 12'd48, 3'd0);
    set_hole(2, 1'b1, 12'd32, 3'd2);
    look("R5 swapped win 2", 32'h0420_0000, 1'b0, 32'h0200_0000, 1'b0);
    look("R5 swapped win 6", 32'h0460_0000, 1'b0, 32'h0300_0000, 1'b0);
    cfg_base();
    @(negedge clk_i);
    set_hole(1, 1'b1, 12'd33, 3'd2);
    look("R2 base low bits ignored", 32'h0200_0000, 1'b1, 32'h0, 1'b0);
    look("R2 masked base reclaim", 32'h0420_0000, 1'b0, 32'h0200_0000, 1'b0);
  endtask

  task automatic t_disable();
    cfg_base();
    @(negedge clk_i);
    hole_en_i[1] = 1'b0;
    look("R6 disabled no hit", 32'h0210_0000, 1'b0, 32'h0210_0000, 1'b0);
    look("R6 shrunk win 2", 32'h0420_0000, 1'b0, 32'h0300_0000, 1'b0);
    look("R6 shrunk win end", 32'h0430_0000, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_errors();
    cfg_base();
    @(negedge clk_i); set_hole(2, 1'b1, 12'd48, 3'd6);
    look("R7 R10 bad size", 32'h0010_0000, 1'b1, 32'h0, 1'b1);
    @(negedge clk_i); set_hole(2, 1'b0, 12'd48, 3'd7);
    look("R7 bad size disabled", 32'h0010_0000, 1'b0, 32'h0010_0000, 1'b0);
    cfg_base();
    @(negedge clk_i); set_hole(0, 1'b1, 12'd40, 3'd1);
    look("R8 low not lowest", 32'h0010_0000, 1'b1, 32'h0, 1'b1);
    @(negedge clk_i); hole_en_i[0] = 1'b0;
    look("R8 low disabled", 32'h0010_0000, 1'b0, 32'h0010_0000, 1'b0);
    cfg_base();
    @(negedge clk_i); set_hole(2, 1'b1, 12'd34, 3'd0);
    look("R9 R10 overlap", 32'h0010_0000, 1'b1, 32'h0, 1'b1);
  endtask

  task automatic t_latency();
    cfg_base();
    look("R11 prior", 32'h0010_0000, 1'b0, 32'h0010_0000, 1'b0);
    @(negedge clk_i);
    addr_i = 32'h0110_0000;
    #1;
    chk("R11 before edge", 32'(to_pci_o), 32'd0);
    @(negedge clk_i);
    chk("R11 after edge", 32'(to_pci_o), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_holes();
    t_reclaim();
    t_swap_and_mask();
    t_disable();
    t_errors();
    t_latency();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule